// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block decides when a program or erase operation running inside a parallel NOR flash device has finished. After the host logic has issued the command sequence, it pulses a start strobe together with a flag that says whether the operation is an erase or a program. The poller then reads the device status at a fixed base address in back-to-back pairs. It watches one status bit that flips on every read while the device is busy. When two consecutive reads agree on that bit, the operation is over.

If the busy bit flipped and the device also raised its internal time-limit flag on the second read, the poller does one immediate confirmation pair before it gives up on the attempt. Between unsuccessful attempts it waits a delay expressed in microseconds and converted to clock cycles. The erase delay is longer than the program delay. After a bounded number of attempts the poller stops and reports a timeout.

Read data comes back a fixed number of cycles after each read strobe. The block ends every poll with a one-cycle done pulse and a sticky pass or timeout result.

Top module: `flash_toggle_poller`

## Requirements
- R1: After reset, busy_o, done_o, rd_req_o, pass_o and timeout_o are all 0.
- R2: A start_i sampled while idle produces the first read strobe in the next cycle. Every read strobe lasts one cycle and presents rd_addr_o equal to BASE_ADDR.
- R3: Read data is sampled RD_LAT cycles after its strobe cycle. The second strobe of a pair follows the first by RD_LAT+2 cycles.
- R4: The busy bit is rd_data_i bit TOG_BIT (6). When it is equal in both reads of a pair, the poll ends with pass. done_o rises RD_LAT+2 cycles after the pair's second strobe. All bits other than TOG_BIT and ERR_BIT (5) are ignored.
- R5: If the busy bit differs within a primary pair and ERR_BIT of its second read is 1, a confirmation pair starts RD_LAT+2 cycles after the second strobe, with no delay. A stable busy bit in the confirmation pair gives pass. ERR_BIT of a confirmation pair is ignored.
- R6: An attempt that is still toggling is followed by a wait. The next first strobe comes RD_LAT+2+D cycles after the last strobe. D is CLK_HZ/1e6*ERASE_US when erase_i was 1 at start, and CLK_HZ/1e6*PROG_US otherwise.
- R7: When the MAX_TRIES-th attempt still toggles, the poll ends at once with timeout and pass 0. No further reads are made and no delay is inserted.
- R8: start_i and erase_i are ignored while busy_o is 1: they change neither timing nor result.
- R9: done_o is a single-cycle pulse. Exactly one of pass_o and timeout_o is 1 from the done cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a poll (accepted when idle) |
| erase_i | input | 1 | 1: erase delay, 0: program delay; sampled with start |
| rd_req_o | output | 1 | One-cycle read strobe to the flash |
| rd_addr_o | output | AW | Read address, always BASE_ADDR |
| rd_data_i | input | DW | Flash read data, valid RD_LAT cycles after the strobe |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle pulse at the end of a poll |
| pass_o | output | 1 | Operation completed |
| timeout_o | output | 1 | Attempts exhausted |

## Verification
The assertions assume that rd_data_i is stable from the strobe until the sampling cycle. They also assume the configured latency covers the device access time, so one read never overlaps the next. The bench flash model changes its data only on the falling edge of a strobe cycle and holds it until the next strobe, which keeps within both assumptions. The bench sweeps the cycle at which the device stops toggling, the time-limit flag, and the erase/program flag over a small configuration. Noise on the unused data bits exercises the bit selection.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_A,
    ST_WAIT_A,
    ST_REQ_B,
    ST_WAIT_B,
    ST_DELAY
  } poll_state_e;

  function automatic int unsigned us_to_cycles(int unsigned hz, int unsigned us);
    return (hz / 1_000_000) * us;
  endfunction
endpackage

// File: rtl/poll_read_port.sv
module poll_read_port #(
  parameter int unsigned DW     = 8,
  parameter int unsigned RD_LAT = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          rd_req_o,
  output logic [DW-1:0] data_o,
  output logic          valid_o
);
  localparam int unsigned LW = $clog2(RD_LAT + 1);

  logic [LW-1:0] lat_q;
  logic [DW-1:0] data_q;
  logic          valid_q;

  assign rd_req_o = req_i;
  assign data_o   = data_q;
  assign valid_o  = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= (lat_q == LW'(1));
      if (lat_q == LW'(1)) data_q <= rd_data_i;
      if (req_i) lat_q <= LW'(RD_LAT);
      else if (lat_q != '0) lat_q <= lat_q - LW'(1);
    end
  end

  // a new strobe must never start while a read is still in flight
  assert_no_overlap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> (lat_q == '0));
endmodule

// File: rtl/poll_delay_timer.sv
module poll_delay_timer #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  assign expired_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end

  assert_count_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/poll_fsm.sv
module poll_fsm
  import poll_pkg::*;
#(
  parameter int unsigned MAX_TRIES = 50000,
  parameter int unsigned CW        = 12,
  parameter int unsigned ERASE_CYC = 2500,
  parameter int unsigned PROG_CYC  = 500
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          erase_i,
  input  logic          rd_valid_i,
  input  logic          tog_bit_i,
  input  logic          err_bit_i,
  input  logic          tmr_expired_i,
  output logic          rd_go_o,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          timeout_o
);
  localparam int unsigned TW = $clog2(MAX_TRIES + 1);

  poll_state_e   state_q;
  logic          first_q, confirm_q, erase_q;
  logic          done_q, pass_q, timeout_q;
  logic [TW-1:0] tries_q;

  logic eval, toggled, take_confirm, give_up, wait_more;

  assign eval         = (state_q == ST_WAIT_B) && rd_valid_i;
  assign toggled      = first_q ^ tog_bit_i;
  assign take_confirm = toggled && err_bit_i && !confirm_q;
  assign give_up      = toggled && !take_confirm && (tries_q == TW'(MAX_TRIES - 1));
  assign wait_more    = toggled && !take_confirm && !give_up;

  assign tmr_load_o = eval && wait_more;
  assign tmr_val_o  = erase_q ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
  assign rd_go_o    = (state_q == ST_REQ_A) || (state_q == ST_REQ_B);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign pass_o     = pass_q;
  assign timeout_o  = timeout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      first_q   <= 1'b0;
      confirm_q <= 1'b0;
      erase_q   <= 1'b0;
      tries_q   <= '0;
      done_q    <= 1'b0;
      pass_q    <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_REQ_A;
          erase_q   <= erase_i;
          tries_q   <= '0;
          confirm_q <= 1'b0;
          pass_q    <= 1'b0;
          timeout_q <= 1'b0;
        end
        ST_REQ_A: state_q <= ST_WAIT_A;
        ST_WAIT_A: if (rd_valid_i) begin
          first_q <= tog_bit_i;
          state_q <= ST_REQ_B;
        end
        ST_REQ_B: state_q <= ST_WAIT_B;
        ST_WAIT_B: if (rd_valid_i) begin
          if (!toggled) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            pass_q  <= 1'b1;
          end else if (take_confirm) begin
            confirm_q <= 1'b1;
            state_q   <= ST_REQ_A;
          end else if (give_up) begin
            state_q   <= ST_IDLE;
            done_q    <= 1'b1;
            timeout_q <= 1'b1;
          end else begin
            tries_q   <= tries_q + TW'(1);
            confirm_q <= 1'b0;
            state_q   <= ST_DELAY;
          end
        end
        ST_DELAY: if (tmr_expired_i) state_q <= ST_REQ_A;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_one_result_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pass_o != timeout_o));
  assert_tries_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tries_q < TW'(MAX_TRIES));
  assert_idle_no_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_go_o);
endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
  import poll_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned AW        = 20,
  parameter logic [AW-1:0] BASE_ADDR = '0,
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned ERASE_US  = 50,
  parameter int unsigned PROG_US   = 10,
  parameter int unsigned MAX_TRIES = 50000,
  parameter int unsigned RD_LAT    = 2,
  parameter int unsigned TOG_BIT   = 6,
  parameter int unsigned ERR_BIT   = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          erase_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          timeout_o
);
  localparam int unsigned ERASE_CYC = us_to_cycles(CLK_HZ, ERASE_US);
  localparam int unsigned PROG_CYC  = us_to_cycles(CLK_HZ, PROG_US);
  localparam int unsigned DMAX      = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int unsigned CW        = $clog2(DMAX + 1);
  localparam logic [DW-1:0] USE_MASK = (DW'(1) << TOG_BIT) | (DW'(1) << ERR_BIT);

  logic          rd_go, rd_valid, tmr_load, tmr_expired;
  logic [DW-1:0] rd_data_q;
  logic [CW-1:0] tmr_val;
  logic          unused_data;

  assign rd_addr_o   = BASE_ADDR;
  assign unused_data = ^(rd_data_q & ~USE_MASK);

  poll_read_port #(.DW(DW), .RD_LAT(RD_LAT)) u_rd (
    .clk_i, .rst_ni,
    .req_i    (rd_go),
    .rd_data_i,
    .rd_req_o,
    .data_o   (rd_data_q),
    .valid_o  (rd_valid)
  );

  poll_delay_timer #(.CW(CW)) u_tmr (
    .clk_i, .rst_ni,
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  poll_fsm #(
    .MAX_TRIES(MAX_TRIES), .CW(CW), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)
  ) u_fsm (
    .clk_i, .rst_ni, .start_i, .erase_i,
    .rd_valid_i    (rd_valid),
    .tog_bit_i     (rd_data_q[TOG_BIT]),
    .err_bit_i     (rd_data_q[ERR_BIT]),
    .tmr_expired_i (tmr_expired),
    .rd_go_o       (rd_go),
    .tmr_load_o    (tmr_load),
    .tmr_val_o     (tmr_val),
    .busy_o, .done_o, .pass_o, .timeout_o
  );
endmodule

// File: tb/flash_toggle_poller_test.sv
module flash_toggle_poller_test;
  localparam int L      = 2;
  localparam int AW     = 12;
  localparam int CLK_HZ = 2_000_000;
  localparam int E_US   = 3;
  localparam int P_US   = 1;
  localparam int MAXT   = 5;
  localparam logic [AW-1:0] BASE = 12'h155;
  localparam int ERASE_D = (CLK_HZ / 1_000_000) * E_US;
  localparam int PROG_D  = (CLK_HZ / 1_000_000) * P_US;

  logic clk = 0, rst_n = 0, start = 0, erase = 0;
  logic rd_req, busy, done, pass, tmo;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data = 8'h00;

  int cyc = 0, tests = 0, fails = 0;
  int mk = 0, mdq5 = 0, rd_idx = 0, addr_err = 0, t_rd0 = 0, t_rd1 = 0;
  int done_cnt = 0, done_cyc = 0, done_pass = 0, done_to = 0;

  always #10 clk = ~clk;

  flash_toggle_poller #(
    .DW(8), .AW(AW), .BASE_ADDR(BASE), .CLK_HZ(CLK_HZ), .ERASE_US(E_US),
    .PROG_US(P_US), .MAX_TRIES(MAXT), .RD_LAT(L), .TOG_BIT(6), .ERR_BIT(5)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .erase_i(erase),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .busy_o(busy), .done_o(done), .pass_o(pass), .timeout_o(tmo)
  );

  function automatic logic [7:0] fval(int idx, int k, int dq5);
    logic [7:0] v;
    v = 8'((idx * 53 + 17) & 8'h9F);
    v[6] = (idx < k) ? idx[0] : 1'b1;
    v[5] = dq5[0];
    return v;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // flash model and observers, updated away from the active edge
  always @(negedge clk) begin
    if (rd_req) begin
      if (rd_addr != BASE) addr_err++;
      if (rd_idx == 0) t_rd0 = cyc;
      if (rd_idx == 1) t_rd1 = cyc;
      rd_data = fval(rd_idx, mk, mdq5);
      rd_idx++;
    end
    if (done) begin
      done_cnt++;
      done_cyc  = cyc;
      done_pass = int'(pass);
      done_to   = int'(tmo);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // arithmetic expectation from the requirements
  task automatic expect_case(input int k, input int dq5, input int d,
                             output int e_pass, output int e_reads, output int e_off);
    int idx = 0, t = 1, tries = 0, conf = 0;
    logic [7:0] a, b;
    forever begin
      a = fval(idx, k, dq5);
      b = fval(idx + 1, k, dq5);
      idx += 2;
      if (a[6] == b[6]) begin e_pass = 1; e_off = t + 2*L + 4; break; end
      if (conf == 0 && b[5]) begin conf = 1; t += 2*L + 4; continue; end
      tries++;
      if (tries == MAXT) begin e_pass = 0; e_off = t + 2*L + 4; break; end
      conf = 0;
      t += 2*L + 4 + d;
    end
    e_reads = idx;
  endtask

  task automatic run_case(input int k, input int dq5, input int er, input bit poke);
    int s, e_pass, e_reads, e_off, n;
    expect_case(k, dq5, er ? ERASE_D : PROG_D, e_pass, e_reads, e_off);
    @(negedge clk);
    mk = k; mdq5 = dq5; rd_idx = 0; addr_err = 0; done_cnt = 0;
    start = 1; erase = er[0]; s = cyc;
    @(negedge clk);
    start = 0; erase = 0;
    if (poke) begin
      repeat (4) @(negedge clk);
      start = 1; erase = ~er[0];   // R8: must be ignored
      @(negedge clk);
      start = 0; erase = 0;
    end
    n = 0;
    while (done_cnt == 0 && n < 3000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R9 done pulse count", done_cnt, 1);
    chk(done_pass == e_pass && done_to == 1 - e_pass,
        e_pass ? "R4 pass result" : "R7 timeout result", done_pass, e_pass);
    chk(done_cyc - s == e_off, poke ? "R8 done cycle" : "R6 done cycle", done_cyc - s, e_off);
    chk(rd_idx == e_reads, "R5 read count", rd_idx, e_reads);
    chk(addr_err == 0, "R2 read address", addr_err, 0);
    chk(t_rd0 == s + 1, "R2 first strobe", t_rd0 - s, 1);
    chk(t_rd1 - t_rd0 == L + 2, "R3 pair spacing", t_rd1 - t_rd0, L + 2);
    chk(int'(pass) == e_pass && int'(tmo) == 1 - e_pass && !busy,
        "R9 result hold", int'(pass), e_pass);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_req && !pass && !tmo, "R1 reset state",
        int'({busy, done, rd_req, pass, tmo}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !rd_req, "R1 idle after release", int'({busy, rd_req}), 0);
    for (int k = 0; k < 25; k++)
      for (int q = 0; q < 2; q++)
        for (int er = 0; er < 2; er++)
          run_case(k, q, er, 1'b0);
    run_case(5, 0, 0, 1'b1);
    run_case(3, 1, 1, 1'b1);
    run_case(30, 0, 1, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected 0", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule